// File: doc/BRIEF.md
# Port Control-Line Handshake and Interrupt Controller

This block handles the control lines of a two-sided parallel port. Each side (A and B) has one input-only line (CA1, CB1) and one line that can be an input or an output (CA2, CB2). A mode register picks, for each side, the active edge of the input line. It also picks how the second line behaves. As an input, that line raises a flag on a chosen edge. As an output, it can give a handshake, a one-clock pulse or a fixed level.

Seven interrupt sources share a flag register and an enable register. Two timer events and a shift-register event come in from outside as one-cycle pulses. The other four sources are the edge detectors on the four control lines. The block drives one active-high interrupt request.

The processor side reaches the block through a small synchronous register bus. Any access to one of the port data addresses counts as a port access, whether it is a read or a write. The port data paths are outside this block. Their accesses only trigger the handshake and clear flags.

Top module: `port_hsk_irq`

Register addresses (bus_addr): 0 = port B data, 1 = port A data with handshake, 2 = mode register, 3 = flag register, 4 = enable register, 5 = port A data without handshake. Mode register fields:
- bit 0: CA1 edge (1 = rising, 0 = falling).
- bits 3:1: CA2 mode.
- bit 4: CB1 edge (1 = rising, 0 = falling).
- bits 7:5: CB2 mode.

Flag and enable bit positions:
- bit 6: timer 1
- bit 5: timer 2
- bit 4: CB1
- bit 3: CB2
- bit 2: shift register
- bit 1: CA1
- bit 0: CA2

Each second-line output is run by a three-state machine:
- LINE_HIGH: the line is idle high.
- HS_LOW: low, waiting for the handshake to complete.
- PULSE_LOW: low for one clock.

Its transitions are:
- LINE_HIGH→HS_LOW on a port access in mode 100.
- LINE_HIGH→PULSE_LOW on a port access in mode 101.
- HS_LOW→LINE_HIGH on the active edge of the side's first line, or when the mode leaves 100.
- PULSE_LOW→LINE_HIGH on the next clock, unless a new access restarts the pulse or starts a handshake.

## Requirements
- R1: After reset, the mode, flag and enable registers are zero, and the enable register reads 0x80. irq is low, and ca2_oe and cb2_oe are low.
- R2: With the control lines idle high, a CA1 edge sets flag bit 1 and a CB1 edge sets flag bit 4, one clock after the edge. The edge is rising when mode bit 0 (CA1) or mode bit 4 (CB1) is 1, and falling when it is 0. The opposite edge sets nothing.
- R3: Second-line mode 000 (falling edge) or 010 (rising edge) makes CA2 or CB2 an input (oe low). The chosen edge sets flag bit 0 (CA2) or bit 3 (CB2). A read or write at that side's port address clears the flag.
- R4: Second-line modes 001 (falling) and 011 (rising) set the flag in the same way, but a port access leaves the flag unchanged.
- R5: In mode 100, the line is driven low from the clock after a port access at address 1 (A) or 0 (B). It stays low until the side's first line shows its active edge, and it is high from the clock after that edge.
- R6: In mode 101, a port access drives the line low for exactly one clock. After that it is high.
- R7: In mode 110 the line is driven low, and in mode 111 it is driven high. oe is high in both modes.
- R8: An access at address 5 does not start the CA2 handshake or pulse, and it does not clear the CA1 or CA2 flag. An access at address 1 clears the CA1 flag. An access at address 0 clears the CB1 flag.
- R9: A write to the enable register with bit 7 = 1 sets every enable bit whose data bit is 1. With bit 7 = 0 it clears those bits. Bits written as 0 are unchanged.
- R10: A write to the flag register clears every flag whose data bit is 1. A one-clock pulse on tmr1_evt, tmr2_evt or shift_evt sets flag bit 6, 5 or 2. Flag bit 7 reads as the irq value.
- R11: irq is high exactly when some flag and its enable bit are both set. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (mode, flag, enable; 0 elsewhere) |
| ca1_in | input | 1 | Port A first control line |
| ca2_in | input | 1 | Port A second control line, input side |
| cb1_in | input | 1 | Port B first control line |
| cb2_in | input | 1 | Port B second control line, input side |
| ca2_out | output | 1 | Port A second line output level |
| ca2_oe | output | 1 | Port A second line output enable |
| cb2_out | output | 1 | Port B second line output level |
| cb2_oe | output | 1 | Port B second line output enable |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| shift_evt | input | 1 | Shift register event pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
The embedded properties check, on every cycle, the following:
- The enable register's set and clear semantics.
- That a write of ones to the flag register clears those flags.
- That a set event always wins over a clear.
- That a pulse state never lasts longer than one clock.
- That a handshake stays low until its completing edge.
- That input modes never drive the line.

Only the directed scenarios can show the rest:
- Which edge polarity raises each flag.
- The difference between the two port A addresses.
- That independent modes keep their flag through a port access.
- The exact cycles of the handshake and pulse outputs.
- That the flag read-back bit follows irq.

// File: rtl/port_hsk_pkg.sv
package port_hsk_pkg;

    localparam int unsigned NUM_SRC  = 7;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_SIDE = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_PORTB   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PORTA   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ENABLE  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_PORTA_Q = 3'd5;

    // flag / enable bit positions
    localparam int unsigned BIT_CA2 = 0;
    localparam int unsigned BIT_CA1 = 1;
    localparam int unsigned BIT_SR  = 2;
    localparam int unsigned BIT_CB2 = 3;
    localparam int unsigned BIT_CB1 = 4;
    localparam int unsigned BIT_T2  = 5;
    localparam int unsigned BIT_T1  = 6;

    // second-line mode codes
    localparam logic [2:0] M2_HANDSHAKE = 3'b100;
    localparam logic [2:0] M2_PULSE     = 3'b101;
    localparam logic [2:0] M2_FORCE_LO  = 3'b110;
    localparam logic [2:0] M2_FORCE_HI  = 3'b111;

    typedef enum logic [1:0] {
        LINE_HIGH = 2'd0,
        HS_LOW    = 2'd1,
        PULSE_LOW = 2'd2
    } line_state_t;

endpackage

// File: rtl/ctl_edge_det.sv
module ctl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_in;
    end

    always_comb begin
        if (rise_sel) hit = sig_in & ~prev_q;
        else          hit = ~sig_in & prev_q;
    end

endmodule

// File: rtl/line_out_fsm.sv
module line_out_fsm
    import port_hsk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       port_acc,
    input  logic       first_hit,
    output logic       line_out,
    output logic       line_oe
);
    line_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_HIGH: begin
                if (port_acc && mode == M2_HANDSHAKE)  state_d = HS_LOW;
                else if (port_acc && mode == M2_PULSE) state_d = PULSE_LOW;
            end
            HS_LOW: begin
                if (mode != M2_HANDSHAKE) state_d = LINE_HIGH;
                else if (port_acc)        state_d = HS_LOW;
                else if (first_hit)       state_d = LINE_HIGH;
            end
            PULSE_LOW: begin
                if (port_acc && mode == M2_PULSE)          state_d = PULSE_LOW;
                else if (port_acc && mode == M2_HANDSHAKE) state_d = HS_LOW;
                else                                       state_d = LINE_HIGH;
            end
            default: state_d = LINE_HIGH;
        endcase
    end

    always_comb begin
        line_out = 1'b1;
        line_oe  = 1'b1;
        unique case (mode)
            M2_HANDSHAKE: line_out = (state_q != HS_LOW);
            M2_PULSE:     line_out = (state_q != PULSE_LOW);
            M2_FORCE_LO:  line_out = 1'b0;
            M2_FORCE_HI:  line_out = 1'b1;
            default:      line_oe  = 1'b0;
        endcase
    end

    // R3
    input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[2] |-> !line_oe);

    // R5
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_LOW && mode == M2_HANDSHAKE && !port_acc && !first_hit)
        |=> (state_q == HS_LOW));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PULSE_LOW && !port_acc) |=> (state_q == LINE_HIGH));

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import port_hsk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] acc_clr,
    input  logic               wr_flag,
    input  logic               wr_enable,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] flags,
    output logic [NUM_SRC-1:0] enables,
    output logic               irq
);
    localparam int unsigned TOP = DATA_W - 1;

    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        clr_vec = acc_clr;
        if (wr_flag) clr_vec = clr_vec | wdata[NUM_SRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (wr_enable) begin
                if (wdata[TOP]) enables <= enables | wdata[NUM_SRC-1:0];
                else            enables <= enables & ~wdata[NUM_SRC-1:0];
            end
        end
    end

    assign irq = |(flags & enables);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R9
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && wdata[TOP])
        |=> ((enables & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    // R9
    enable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wdata[TOP])
        |=> ((enables & $past(wdata[NUM_SRC-1:0])) == '0));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag |=> ((flags & $past(wdata[NUM_SRC-1:0] & ~set_vec)) == '0));

endmodule

// File: rtl/port_hsk_irq.sv
module port_hsk_irq
    import port_hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ca1_in,
    input  logic              ca2_in,
    input  logic              cb1_in,
    input  logic              cb2_in,
    output logic              ca2_out,
    output logic              ca2_oe,
    output logic              cb2_out,
    output logic              cb2_oe,
    input  logic              tmr1_evt,
    input  logic              tmr2_evt,
    input  logic              shift_evt,
    output logic              irq
);
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;
    localparam int unsigned FIELD_W = DATA_W / NUM_SIDE;

    logic [DATA_W-1:0] mode_q;
    logic [NUM_SRC-1:0] flags, enables, set_vec, acc_clr;

    logic [NUM_SIDE-1:0] first_in, second_in, port_acc;
    logic [NUM_SIDE-1:0] first_hit, second_hit, second_clr_ok;
    logic [NUM_SIDE-1:0] line_out, line_oe;

    logic wr_mode, wr_flag, wr_enable;

    assign wr_mode   = bus_sel && bus_wr && bus_addr == ADR_MODE;
    assign wr_flag   = bus_sel && bus_wr && bus_addr == ADR_FLAG;
    assign wr_enable = bus_sel && bus_wr && bus_addr == ADR_ENABLE;

    assign port_acc[SIDE_A] = bus_sel && bus_addr == ADR_PORTA;
    assign port_acc[SIDE_B] = bus_sel && bus_addr == ADR_PORTB;

    assign first_in  = {cb1_in, ca1_in};
    assign second_in = {cb2_in, ca2_in};

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (wr_mode) mode_q <= bus_wdata;
    end

    for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
        logic       edge_rise;
        logic [2:0] sec_mode;
        logic       sec_raw_hit;

        assign edge_rise = mode_q[s*FIELD_W];
        assign sec_mode  = mode_q[s*FIELD_W+1 +: 3];

        ctl_edge_det u_first_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (first_in[s]),
            .rise_sel (edge_rise),
            .hit      (first_hit[s])
        );

        ctl_edge_det u_second_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (second_in[s]),
            .rise_sel (sec_mode[1]),
            .hit      (sec_raw_hit)
        );

        assign second_hit[s]    = sec_raw_hit & ~sec_mode[2];
        assign second_clr_ok[s] = sec_mode[2] | ~sec_mode[0];

        line_out_fsm u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (sec_mode),
            .port_acc  (port_acc[s]),
            .first_hit (first_hit[s]),
            .line_out  (line_out[s]),
            .line_oe   (line_oe[s])
        );
    end

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_T1]  = tmr1_evt;
        set_vec[BIT_T2]  = tmr2_evt;
        set_vec[BIT_SR]  = shift_evt;
        set_vec[BIT_CA1] = first_hit[SIDE_A];
        set_vec[BIT_CB1] = first_hit[SIDE_B];
        set_vec[BIT_CA2] = second_hit[SIDE_A];
        set_vec[BIT_CB2] = second_hit[SIDE_B];

        acc_clr          = '0;
        acc_clr[BIT_CA1] = port_acc[SIDE_A];
        acc_clr[BIT_CB1] = port_acc[SIDE_B];
        acc_clr[BIT_CA2] = port_acc[SIDE_A] & second_clr_ok[SIDE_A];
        acc_clr[BIT_CB2] = port_acc[SIDE_B] & second_clr_ok[SIDE_B];
    end

    irq_flag_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .acc_clr   (acc_clr),
        .wr_flag   (wr_flag),
        .wr_enable (wr_enable),
        .wdata     (bus_wdata),
        .flags     (flags),
        .enables   (enables),
        .irq       (irq)
    );

    always_comb begin
        unique case (bus_addr)
            ADR_MODE:   bus_rdata = mode_q;
            ADR_FLAG:   bus_rdata = {irq, flags};
            ADR_ENABLE: bus_rdata = {1'b1, enables};
            default:    bus_rdata = '0;
        endcase
    end

    assign ca2_out = line_out[SIDE_A];
    assign ca2_oe  = line_oe[SIDE_A];
    assign cb2_out = line_out[SIDE_B];
    assign cb2_oe  = line_oe[SIDE_B];

    // R8
    quiet_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADR_PORTA_Q && flags[BIT_CA1]) |=> flags[BIT_CA1]);

endmodule

// File: tb/port_hsk_irq_test.sv
`timescale 1ns/1ps
module port_hsk_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd2;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ca1_in = 1'b1, ca2_in = 1'b1, cb1_in = 1'b1, cb2_in = 1'b1;
    logic       ca2_out, ca2_oe, cb2_out, cb2_oe;
    logic       tmr1_evt = 1'b0, tmr2_evt = 1'b0, shift_evt = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    port_hsk_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ca1_in(ca1_in), .ca2_in(ca2_in), .cb1_in(cb1_in), .cb2_in(cb2_in),
        .ca2_out(ca2_out), .ca2_oe(ca2_oe), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
        .tmr1_evt(tmr1_evt), .tmr2_evt(tmr2_evt), .shift_evt(shift_evt),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic port_read(input logic [2:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd2, v); check("R1 mode reg", v, 8'h00);
        rd(3'd3, v); check("R1 flag reg", v, 8'h00);
        rd(3'd4, v); check("R1 enable reg", v, 8'h80);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 oe pair", {6'd0, cb2_oe, ca2_oe}, 8'h00);
    endtask

    task automatic t_first_edges();
        logic [7:0] v;
        wr(3'd2, 8'h00);
        @(negedge clk); ca1_in = 1'b0; idle(1);
        rd(3'd3, v); check("R2 CA1 falling sets bit1", v, 8'h02);
        wr(3'd3, 8'h02);
        @(negedge clk); ca1_in = 1'b1; idle(1);
        rd(3'd3, v); check("R2 CA1 rising ignored in falling mode", v, 8'h00);
        wr(3'd2, 8'h11);
        @(negedge clk); ca1_in = 1'b0; cb1_in = 1'b0; idle(1);
        rd(3'd3, v); check("R2 falling ignored in rising mode", v, 8'h00);
        @(negedge clk); ca1_in = 1'b1; cb1_in = 1'b1; idle(1);
        rd(3'd3, v); check("R2 CA1 and CB1 rising set bits 1 and 4", v, 8'h12);
        port_read(3'd5);
        rd(3'd3, v); check("R8 address 5 leaves CA1 flag", v, 8'h12);
        wr(3'd1, 8'h00);
        rd(3'd3, v); check("R8 address 1 clears CA1 flag", v, 8'h10);
        port_read(3'd0);
        rd(3'd3, v); check("R8 address 0 clears CB1 flag", v, 8'h00);
    endtask

    task automatic t_second_inputs();
        logic [7:0] v;
        wr(3'd2, 8'h00);
        @(negedge clk); ca2_in = 1'b0; idle(1);
        rd(3'd3, v); check("R3 CA2 falling sets bit0", v, 8'h01);
        check("R3 CA2 not driven in input mode", {7'd0, ca2_oe}, 8'h00);
        port_read(3'd1);
        rd(3'd3, v); check("R3 port A read clears CA2 flag", v, 8'h00);
        @(negedge clk); ca2_in = 1'b1; idle(1);
        rd(3'd3, v); check("R3 CA2 rising ignored in mode 000", v, 8'h00);
        wr(3'd2, 8'h06);
        @(negedge clk); ca2_in = 1'b0; idle(1);
        @(negedge clk); ca2_in = 1'b1; idle(1);
        rd(3'd3, v); check("R4 CA2 rising sets bit0 in mode 011", v, 8'h01);
        wr(3'd1, 8'h55);
        rd(3'd3, v); check("R4 port access keeps independent flag", v, 8'h01);
        wr(3'd3, 8'h01);
        rd(3'd3, v); check("R10 flag write clears bit0", v, 8'h00);
        wr(3'd2, 8'h40);
        @(negedge clk); cb2_in = 1'b0; idle(1);
        rd(3'd3, v); check("R3 CB2 falling ignored in mode 010", v, 8'h00);
        @(negedge clk); cb2_in = 1'b1; idle(1);
        rd(3'd3, v); check("R3 CB2 rising sets bit3", v, 8'h08);
        port_read(3'd0);
        rd(3'd3, v); check("R3 port B read clears CB2 flag", v, 8'h00);
    endtask

    task automatic t_handshake();
        wr(3'd2, 8'h09);
        check("R5 idle handshake line high and driven", {6'd0, ca2_oe, ca2_out}, 8'h03);
        wr(3'd1, 8'h00);
        check("R5 line low after port access", {7'd0, ca2_out}, 8'h00);
        idle(3);
        check("R5 line held low", {7'd0, ca2_out}, 8'h00);
        @(negedge clk); ca1_in = 1'b0; idle(1);
        check("R5 inactive edge keeps line low", {7'd0, ca2_out}, 8'h00);
        @(negedge clk); ca1_in = 1'b1; #1;
        check("R5 still low before clock", {7'd0, ca2_out}, 8'h00);
        idle(1);
        check("R5 active edge returns line high", {7'd0, ca2_out}, 8'h01);
        wr(3'd3, 8'h7F);
    endtask

    task automatic t_pulse();
        wr(3'd2, 8'hA0);
        check("R6 idle pulse line high", {6'd0, cb2_oe, cb2_out}, 8'h03);
        port_read(3'd0);
        check("R6 pulse low first clock", {7'd0, cb2_out}, 8'h00);
        idle(1);
        check("R6 pulse high after one clock", {7'd0, cb2_out}, 8'h01);
        wr(3'd2, 8'h0A);
        wr(3'd5, 8'h00);
        check("R8 address 5 gives no pulse", {7'd0, ca2_out}, 8'h01);
        idle(1);
        check("R8 address 5 still no pulse", {7'd0, ca2_out}, 8'h01);
    endtask

    task automatic t_manual();
        wr(3'd2, 8'hEC);
        check("R7 CA2 forced low", {6'd0, ca2_oe, ca2_out}, 8'h02);
        check("R7 CB2 forced high", {6'd0, cb2_oe, cb2_out}, 8'h03);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(3'd4, 8'hC0);
        rd(3'd4, v); check("R9 enable set bit6", v, 8'hC0);
        @(negedge clk); tmr1_evt = 1'b1; @(negedge clk); tmr1_evt = 1'b0; #1;
        rd(3'd3, v); check("R10 timer1 sets bit6, bit7 follows irq", v, 8'hC0);
        check("R11 irq with enabled flag", {7'd0, irq}, 8'h01);
        @(negedge clk); tmr2_evt = 1'b1; @(negedge clk); tmr2_evt = 1'b0; #1;
        wr(3'd4, 8'h40);
        rd(3'd4, v); check("R9 enable clear bit6", v, 8'h80);
        rd(3'd3, v); check("R11 no irq when nothing enabled", v, 8'h60);
        wr(3'd4, 8'hA0);
        check("R11 irq from timer2", {7'd0, irq}, 8'h01);
        wr(3'd3, 8'h20);
        rd(3'd3, v); check("R10 clear bit5 only", v, 8'h40);
        @(negedge clk); shift_evt = 1'b1; @(negedge clk); shift_evt = 1'b0; #1;
        rd(3'd3, v); check("R10 shift event sets bit2", v, 8'h44);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h40; tmr1_evt = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tmr1_evt = 1'b0; #1;
        rd(3'd3, v); check("R11 set wins over clear", v, 8'h44);
        wr(3'd4, 8'h84);
        rd(3'd4, v); check("R9 zeros leave bit5 enabled", v, 8'hA4);
        check("R11 irq from shift flag", {7'd0, irq}, 8'h01);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_first_edges();
        t_second_inputs();
        t_handshake();
        t_pulse();
        t_manual();
        t_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule